// File: doc/BRIEF.md
# Per-Frame Video Sync Statistics

This block sits in the pixel clock domain of a parallel video receiver and measures the timing of the three sync flags that come with the pixels: frame-valid, line-valid and data-valid. A frame begins on each rising edge of frame-valid. For every frame, the block keeps a count of the clock cycles in which each flag was high. These counts go into three separate register arrays, one entry per frame.

Recording covers a fixed number of frames after reset (24 by default). Frames that arrive after that leave the stored counts unchanged. Once the last recorded frame has closed, a done flag rises. An indexed read port returns any stored count one cycle after it is addressed. Comparing the counts with the expected resolution of the source shows whether lines or pixels were dropped.

Top module: `vid_sync_stats`

## Requirements
- R1: A frame start is a cycle in which frame-valid is high after a cycle in which it was low. Each accepted frame start raises frame_cnt_o by one, and the new value is visible after that same clock edge.
- R2: Only the first NUM_FRAMES (24) frame starts are accepted. frame_cnt_o stops at 24, and later frames change no stored count.
- R3: For the k-th accepted frame (k counted from 0), entry k of each array counts the cycles from the frame-start cycle up to the last cycle before frame-valid falls in which that flag is high. The frame-valid entry therefore equals the length of the high period. Counts are 32 bits wide.
- R4: Line-valid or data-valid that is high while frame-valid is low is not counted. No cycle before the first frame start after reset is counted.
- R5: An active-low reset clears every array entry, frame_cnt_o and done_o to zero.
- R6: The read port works as follows:
  - rd_sel_i 0 selects line-valid, 1 selects frame-valid and 2 selects data-valid. rd_sel_i 3 returns zero.
  - rd_data_o shows the entry at rd_idx_i after the next rising clock edge.
  - An index of 24 or above returns zero.
- R7: done_o rises at the clock edge of the first cycle in which frame-valid is low after the last accepted frame. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fval_i | input | 1 | Frame-valid flag |
| lval_i | input | 1 | Line-valid flag |
| dval_i | input | 1 | Data-valid flag |
| rd_idx_i | input | 5 | Frame index to read |
| rd_sel_i | input | 2 | Flag select: 0 line, 1 frame, 2 data, 3 none |
| rd_data_o | output | 32 | Registered count read back |
| frame_cnt_o | output | 5 | Number of accepted frames |
| done_o | output | 1 | All recorded frames have closed |

## Verification
The bench builds the block with its default parameters: 24 frames and 32-bit counts. With these values, the full recording window and the saturation after it fit in a short run. The stimulus uses frames of random length, down to a single cycle, separated by gaps as short as one low cycle, with random flag activity in the blanking gaps. Reading all 32 index values under all four select codes covers the unused slots and the zero select.

// File: rtl/vid_sync_stats_pkg.sv
package vid_sync_stats_pkg;
  typedef enum logic [1:0] {
    SEL_LINE  = 2'd0,
    SEL_FRAME = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_NONE  = 2'd3
  } stat_sel_e;

  localparam int unsigned NUM_FLAGS = 3;
endpackage

// File: rtl/vid_frame_track.sv
module vid_frame_track #(
  parameter int unsigned NUM_FRAMES = 24,
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned FC_W       = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fval_i,
  output logic             count_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [FC_W-1:0]  frame_cnt_o,
  output logic             done_o
);
  logic             fval_q;
  logic             in_frame_q;
  logic             done_q;
  logic [FC_W-1:0]  frame_cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             rise;
  logic             accept;
  logic             last_frame;

  assign rise       = fval_i & ~fval_q;
  assign accept     = rise & (frame_cnt_q < FC_W'(NUM_FRAMES));
  assign last_frame = (frame_cnt_q == FC_W'(NUM_FRAMES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fval_q      <= 1'b0;
      in_frame_q  <= 1'b0;
      done_q      <= 1'b0;
      frame_cnt_q <= '0;
      idx_q       <= '0;
    end else begin
      fval_q <= fval_i;
      if (accept) begin
        frame_cnt_q <= frame_cnt_q + 1'b1;
        idx_q       <= frame_cnt_q[IDX_W-1:0];
        in_frame_q  <= 1'b1;
      end else if (!fval_i) begin
        in_frame_q <= 1'b0;
      end
      // frame closes on first low cycle after last accepted start
      if (!fval_i && in_frame_q && last_frame) done_q <= 1'b1;
    end
  end

  assign count_en_o  = fval_i & (accept | in_frame_q);
  assign wr_idx_o    = accept ? frame_cnt_q[IDX_W-1:0] : idx_q;
  assign frame_cnt_o = frame_cnt_q;
  assign done_o      = done_q;
endmodule

// File: rtl/vid_cnt_bank.sv
module vid_cnt_bank #(
  parameter int unsigned DEPTH = 24,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_val_o
);
  logic [CNT_W-1:0] cnt_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   cnt_q[e] <= '0;
      else if (inc_i && (wr_idx_i == IDX_W'(e)))     cnt_q[e] <= cnt_q[e] + 1'b1;
    end
  end

  always_comb begin
    rd_val_o = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (rd_idx_i == IDX_W'(e)) rd_val_o = cnt_q[e];
    end
  end
endmodule

// File: rtl/vid_stat_rd.sv
module vid_stat_rd
  import vid_sync_stats_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] line_val_i,
  input  logic [CNT_W-1:0] frame_val_i,
  input  logic [CNT_W-1:0] data_val_i,
  output logic [CNT_W-1:0] data_o
);
  logic [CNT_W-1:0] pick;

  always_comb begin
    unique case (stat_sel_e'(sel_i))
      SEL_LINE:  pick = line_val_i;
      SEL_FRAME: pick = frame_val_i;
      SEL_DATA:  pick = data_val_i;
      default:   pick = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= pick;
  end
endmodule

// File: rtl/vid_sync_stats.sv
module vid_sync_stats
  import vid_sync_stats_pkg::*;
#(
  parameter  int unsigned NUM_FRAMES = 24,
  parameter  int unsigned CNT_W      = 32,
  localparam int unsigned IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int unsigned FC_W       = $clog2(NUM_FRAMES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fval_i,
  input  logic             lval_i,
  input  logic             dval_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [1:0]       rd_sel_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic [FC_W-1:0]  frame_cnt_o,
  output logic             done_o
);
  logic                 count_en;
  logic [IDX_W-1:0]     wr_idx;
  logic [NUM_FLAGS-1:0] flags;
  logic [CNT_W-1:0]     bank_val [NUM_FLAGS];

  // flag order follows the read select code
  assign flags = {dval_i, fval_i, lval_i};

  vid_frame_track #(
    .NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W), .FC_W(FC_W)
  ) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fval_i      (fval_i),
    .count_en_o  (count_en),
    .wr_idx_o    (wr_idx),
    .frame_cnt_o (frame_cnt_o),
    .done_o      (done_o)
  );

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_bank
    vid_cnt_bank #(
      .DEPTH(NUM_FRAMES), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (count_en & flags[f]),
      .wr_idx_i (wr_idx),
      .rd_idx_i (rd_idx_i),
      .rd_val_o (bank_val[f])
    );
  end

  vid_stat_rd #(.CNT_W(CNT_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (rd_sel_i),
    .line_val_i  (bank_val[0]),
    .frame_val_i (bank_val[1]),
    .data_val_i  (bank_val[2]),
    .data_o      (rd_data_o)
  );
endmodule

// File: rtl/vid_sync_stats_chk.sv
module vid_sync_stats_chk #(
  parameter int unsigned NUM_FRAMES = 24,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned FC_W       = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fval_i,
  input logic [IDX_W-1:0] rd_idx_i,
  input logic [1:0]       rd_sel_i,
  input logic [CNT_W-1:0] rd_data_o,
  input logic [FC_W-1:0]  frame_cnt_o,
  input logic             done_o
);
  logic fv_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fv_q <= 1'b0;
    else         fv_q <= fval_i;
  end

  assert_frame_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fval_i && !fv_q && frame_cnt_o < FC_W'(NUM_FRAMES)) |=> frame_cnt_o == $past(frame_cnt_o) + 1'b1);

  assert_no_spurious_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fval_i && !fv_q) |=> $stable(frame_cnt_o));

  assert_cnt_saturate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_cnt_o <= FC_W'(NUM_FRAMES));

  assert_zero_sel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == 2'd3) |=> rd_data_o == '0);

  assert_oob_idx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i >= IDX_W'(NUM_FRAMES)) |=> rd_data_o == '0);

  assert_done_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  assert_done_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> frame_cnt_o == FC_W'(NUM_FRAMES));

  assert_done_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !$past(fval_i));
endmodule

bind vid_sync_stats vid_sync_stats_chk #(
  .NUM_FRAMES(NUM_FRAMES), .CNT_W(CNT_W), .IDX_W(IDX_W), .FC_W(FC_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fval_i      (fval_i),
  .rd_idx_i    (rd_idx_i),
  .rd_sel_i    (rd_sel_i),
  .rd_data_o   (rd_data_o),
  .frame_cnt_o (frame_cnt_o),
  .done_o      (done_o)
);

// File: tb/sim_vid_sync_stats.sv
`timescale 1ns/1ps
module sim_vid_sync_stats;
  localparam int NF = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fval = 1'b0, lval = 1'b0, dval = 1'b0;
  logic [4:0]  rd_idx = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic [4:0]  frame_cnt;
  logic        done;

  always #4 clk = ~clk;

  vid_sync_stats u0 (
    .clk_i(clk), .rst_ni(rst_n), .fval_i(fval), .lval_i(lval), .dval_i(dval),
    .rd_idx_i(rd_idx), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .frame_cnt_o(frame_cnt), .done_o(done)
  );

  int unsigned total = 0, bad = 0;
  bit          finished = 0;

  // reference model state
  int unsigned e_cnt [3][NF];
  int unsigned m_fc;
  bit          m_fq, m_in, m_done;
  int unsigned m_idx;
  bit          pend;
  int unsigned pend_exp;
  string       pend_tag;

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_clear();
    for (int s = 0; s < 3; s++) for (int i = 0; i < NF; i++) e_cnt[s][i] = 0;
    m_fc = 0; m_fq = 0; m_in = 0; m_done = 0; m_idx = 0; pend = 0;
  endfunction

  function automatic void model_step(bit f, bit l, bit d);
    if (f && !m_fq && m_fc < NF) begin
      m_in = 1; m_idx = m_fc; m_fc++;
    end else if (!f) begin
      if (m_in && m_fc == NF) m_done = 1;
      m_in = 0;
    end
    if (m_in && f) begin
      if (l) e_cnt[0][m_idx]++;
      e_cnt[1][m_idx]++;
      if (d) e_cnt[2][m_idx]++;
    end
    m_fq = f;
  endfunction

  // one cycle: check outputs of previous edge, then drive next inputs
  task automatic tick(bit f, bit l, bit d);
    @(negedge clk);
    if (pend) chk(pend_tag, rd_data, pend_exp);
    pend = 0;
    chk("R1/R2 frame_cnt", frame_cnt, m_fc);
    chk("R7 done", done, m_done);
    fval = f; lval = l; dval = d;
    model_step(f, l, d);
  endtask

  task automatic probe(int idx, int sel);
    rd_idx = 5'(idx); rd_sel = 2'(sel);
    pend = 1;
    pend_exp = (idx < NF && sel < 3) ? e_cnt[sel][idx] : 0;
    pend_tag = (sel == 3 || idx >= NF) ? "R6 zero read" : "R3/R4 count read";
    tick(0, 0, 0);
  endtask

  task automatic read_all();
    for (int i = 0; i < 32; i++)
      for (int s = 0; s < 4; s++) probe(i, s);
    tick(0, 0, 0);
  endtask

  // gap with noisy flags (R4), then frame with random flag pattern (R3)
  task automatic frame(int gap, int len, int mode);
    for (int g = 0; g < gap; g++) tick(0, 1'($urandom), 1'($urandom));
    for (int c = 0; c < len; c++) begin
      bit l, d;
      case (mode)
        0: begin l = 1'($urandom); d = l & 1'($urandom); end
        1: begin l = 1; d = 1; end
        default: begin l = (c % 5) != 4; d = 0; end
      endcase
      tick(1, l, d);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; fval = 0; lval = 0; dval = 0;
    model_clear();
    @(negedge clk);
    chk("R5 frame_cnt at reset", frame_cnt, 0);
    chk("R5 done at reset", done, 0);
    chk("R5 rd_data at reset", rd_data, 0);
    rst_n = 1;
  endtask

  initial begin
    void'($urandom(32'd20240607));
    model_clear();
    repeat (3) @(negedge clk);
    chk("R5 frame_cnt at reset", frame_cnt, 0);
    chk("R5 done at reset", done, 0);
    rst_n = 1;
    // R4: activity before the first frame start
    for (int i = 0; i < 12; i++) tick(0, 1, 1);
    frame(1, 17, 0);
    frame(3, 9, 1);
    frame(1, 1, 0);   // single-cycle frame, one-cycle gap
    read_all();
    // R5: reset wipes recorded counts
    do_reset();
    read_all();
    // full run: 30 frames, last 6 must not be recorded (R2)
    for (int k = 0; k < 30; k++) begin
      int gap = 1 + int'($urandom % 6);
      int len = 1 + int'($urandom % 40);
      int mode = int'($urandom % 3);
      if (k == 5)  len = 1;
      if (k == 23) len = 2;
      frame(gap, len, mode);
    end
    for (int i = 0; i < 4; i++) tick(0, 1, 1);
    read_all();
    chk("R2 saturated frame_cnt", frame_cnt, NF);
    chk("R7 done held", done, 1);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule